// File: doc/BRIEF.md
# Bank Auto-Precharge Scheduler

This block tracks, bank by bank, whether a row is open and decides the clock edge at which that row is closed. A command port carries activate, read, write and precharge operations with a bank number and an auto-precharge flag, which is taken from column address bit 8 of a read or write. When the flag is set, the bank does not close at once. It closes only when two things are true: the burst has finished, and the bank has been open for its minimum row-active time. For reads, the burst is finished once the last beat has been issued. For writes, it is finished once the write latency, the burst and the write recovery time have all passed.

Each bank has its own countdowns, so banks open, close and recover independently. When a bank closes, the block gives a one-cycle internal precharge start pulse for that bank. The bank then spends a configurable precharge time in the precharging state before it returns to idle. An activate to a bank that is not idle is refused and flagged.

Top module: `apre_sched`

## Requirements
- R1: A read or write with the flag low (cmd_apre=0) leaves the bank ACTIVE, and no precharge start follows for that bank.
- R2: A read with the flag high, sampled at edge tc to a bank activated at edge ta, starts the precharge at edge max(tc+BL, ta+TRAS). BL and TRAS are each taken as at least 1. Starting means that pre_start for that bank is high and its state is PRECH right after that edge.
- R3: A write with the flag high, sampled at edge tc, starts the precharge at edge max(tc+WL+BL+TWR, ta+TRAS).
- R4: The row-active lockout holds back an automatic precharge until TRAS edges have passed since the activate, even when the burst is already complete.
- R5: An explicit precharge (cmd_op=3) to an ACTIVE bank moves it to PRECH at the sampling edge, with a pre_start pulse. To an IDLE or PRECH bank it is ignored.
- R6: A bank stays in PRECH for max(TRP,1) cycles, then returns to IDLE.
- R7: An activate (cmd_op=0) to an IDLE bank makes it ACTIVE at the sampling edge. An activate to a bank that is not IDLE is ignored and raises act_err for the one cycle after that edge.
- R8: A command affects only the bank named by cmd_bank. The other banks keep their state and their countdowns.
- R9: Encodings: cmd_op is 0 for activate, 1 for read, 2 for write and 3 for precharge. The state of bank b sits in bank_state[2b+1:2b], coded 0 for IDLE, 1 for ACTIVE and 2 for PRECH. After reset every bank is IDLE, and pre_start and act_err are zero.
- R10: A read or write to a bank that is not ACTIVE is ignored.
- R11: pre_start for a bank is high for exactly one cycle, and that cycle is the first cycle of PRECH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 2 | Operation: 0 activate, 1 read, 2 write, 3 precharge |
| cmd_bank | input | $clog2(NUM_BANKS) | Target bank |
| cmd_apre | input | 1 | Auto-precharge flag (column address bit 8) |
| cfg_wl | input | CFG_W | Write latency in cycles |
| cfg_bl | input | CFG_W | Burst duration in cycles |
| cfg_twr | input | CFG_W | Write recovery in cycles |
| cfg_tras | input | CFG_W | Minimum row-active time in cycles |
| cfg_trp | input | CFG_W | Precharge time in cycles |
| pre_start | output | NUM_BANKS | One-cycle internal precharge start, one bit per bank |
| bank_state | output | 2*NUM_BANKS | Per-bank state, two bits per bank |
| act_err | output | 1 | Refused activate |

## Verification
The bench builds the block with NUM_BANKS=4 and CFG_W=4. With four banks, every bank index and its field in the state vector are used. The 4-bit configuration allows a row-active time that outlasts the whole read burst, and a separate case where it outlasts the whole write latency plus burst plus recovery. Both ordering cases of the max() in R2 and R3 are therefore reached. Changing the write latency and the recovery time between cases shows that all three terms enter the write window.

// File: rtl/apre_pkg.sv
package apre_pkg;
    typedef enum logic [1:0] {
        OP_ACT = 2'd0,
        OP_RD  = 2'd1,
        OP_WR  = 2'd2,
        OP_PRE = 2'd3
    } apre_op_e;

    typedef enum logic [1:0] {
        BK_IDLE   = 2'd0,
        BK_ACTIVE = 2'd1,
        BK_PRECH  = 2'd2
    } bank_st_e;
endpackage

// File: rtl/apre_cmd_dec.sv
module apre_cmd_dec
    import apre_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = $clog2(NUM_BANKS)
) (
    input  logic                 cmd_valid,
    input  logic [1:0]           cmd_op,
    input  logic [BANK_W-1:0]    cmd_bank,
    output logic [NUM_BANKS-1:0] act_o,
    output logic [NUM_BANKS-1:0] rd_o,
    output logic [NUM_BANKS-1:0] wr_o,
    output logic [NUM_BANKS-1:0] pre_o
);
    always_comb begin
        act_o = '0;
        rd_o  = '0;
        wr_o  = '0;
        pre_o = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (cmd_valid && (cmd_bank == BANK_W'(b))) begin
                act_o[b] = (cmd_op == OP_ACT);
                rd_o[b]  = (cmd_op == OP_RD);
                wr_o[b]  = (cmd_op == OP_WR);
                pre_o[b] = (cmd_op == OP_PRE);
            end
        end
    end
endmodule

// File: rtl/apre_bank.sv
module apre_bank
    import apre_pkg::*;
#(
    parameter int CFG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_i,
    input  logic             rd_i,
    input  logic             wr_i,
    input  logic             pre_i,
    input  logic             apre_i,
    input  logic [CFG_W-1:0] cfg_wl,
    input  logic [CFG_W-1:0] cfg_bl,
    input  logic [CFG_W-1:0] cfg_twr,
    input  logic [CFG_W-1:0] cfg_tras,
    input  logic [CFG_W-1:0] cfg_trp,
    output logic [1:0]       state_o,
    output logic             pre_start_o,
    output logic             act_err_o
);
    localparam int SUM_W = CFG_W + 2;

    typedef struct packed {
        bank_st_e         st;
        logic             pend;
        logic [CFG_W-1:0] ras_left;
        logic [SUM_W-1:0] burst_left;
        logic [CFG_W-1:0] rp_left;
        logic             pre_start;
        logic             act_err;
    } bank_reg_t;

    bank_reg_t r_d, r_q;

    logic [SUM_W-1:0] wr_span, rd_span, burst_dec, burst_load;
    logic [CFG_W-1:0] tras_m1, trp_m1;
    logic             auto_go;

    always_comb begin
        wr_span = SUM_W'(cfg_wl) + SUM_W'(cfg_bl) + SUM_W'(cfg_twr);
        rd_span = SUM_W'(cfg_bl);
        tras_m1 = (cfg_tras == '0) ? '0 : cfg_tras - CFG_W'(1);
        trp_m1  = (cfg_trp == '0) ? '0 : cfg_trp - CFG_W'(1);
        burst_dec = (r_q.burst_left == '0) ? '0 : r_q.burst_left - SUM_W'(1);
        burst_load = wr_i ? wr_span : rd_span;
        burst_load = (burst_load == '0) ? '0 : burst_load - SUM_W'(1);
        auto_go = (r_q.st == BK_ACTIVE) && r_q.pend &&
                  (r_q.burst_left == '0) && (r_q.ras_left == '0);

        r_d            = r_q;
        r_d.pre_start  = 1'b0;
        r_d.act_err    = 1'b0;
        r_d.burst_left = burst_dec;
        if (r_q.ras_left != '0) r_d.ras_left = r_q.ras_left - CFG_W'(1);

        unique case (r_q.st)
            BK_IDLE: begin
                if (act_i) begin
                    r_d.st         = BK_ACTIVE;
                    r_d.ras_left   = tras_m1;
                    r_d.pend       = 1'b0;
                    r_d.burst_left = '0;
                end
            end
            BK_ACTIVE: begin
                r_d.act_err = act_i;
                if (pre_i || auto_go) begin
                    r_d.st        = BK_PRECH;
                    r_d.pre_start = 1'b1;
                    r_d.pend      = 1'b0;
                    r_d.rp_left   = trp_m1;
                end else if (rd_i || wr_i) begin
                    // a shorter read never cuts a pending write recovery
                    if (burst_load > burst_dec) r_d.burst_left = burst_load;
                    r_d.pend = r_q.pend | apre_i;
                end
            end
            BK_PRECH: begin
                r_d.act_err = act_i;
                if (r_q.rp_left == '0) r_d.st = BK_IDLE;
                else r_d.rp_left = r_q.rp_left - CFG_W'(1);
            end
            default: r_d.st = BK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign state_o     = r_q.st;
    assign pre_start_o = r_q.pre_start;
    assign act_err_o   = r_q.act_err;

    AST_NOFLAG_STAYS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == BK_ACTIVE && !r_q.pend && !pre_i) |=> (r_q.st == BK_ACTIVE)); // R1
    AST_NO_REOPEN_FROM_PRECH: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == BK_PRECH) |=> (r_q.st != BK_ACTIVE)); // R6
    AST_LOCKOUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.pre_start && !$past(pre_i)) |-> ($past(r_q.ras_left) == '0 && $past(r_q.burst_left) == '0)); // R4
    AST_PRE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.pre_start |=> !r_q.pre_start); // R11
endmodule

// File: rtl/apre_sched.sv
module apre_sched
    import apre_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int CFG_W     = 4,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cmd_valid,
    input  logic [1:0]             cmd_op,
    input  logic [BANK_W-1:0]      cmd_bank,
    input  logic                   cmd_apre,
    input  logic [CFG_W-1:0]       cfg_wl,
    input  logic [CFG_W-1:0]       cfg_bl,
    input  logic [CFG_W-1:0]       cfg_twr,
    input  logic [CFG_W-1:0]       cfg_tras,
    input  logic [CFG_W-1:0]       cfg_trp,
    output logic [NUM_BANKS-1:0]   pre_start,
    output logic [2*NUM_BANKS-1:0] bank_state,
    output logic                   act_err
);
    logic [NUM_BANKS-1:0] act_s, rd_s, wr_s, pre_s, err_s;

    apre_cmd_dec #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_dec (
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_bank  (cmd_bank),
        .act_o     (act_s),
        .rd_o      (rd_s),
        .wr_o      (wr_s),
        .pre_o     (pre_s)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        apre_bank #(.CFG_W(CFG_W)) u_bank (
            .clk         (clk),
            .rst_n       (rst_n),
            .act_i       (act_s[b]),
            .rd_i        (rd_s[b]),
            .wr_i        (wr_s[b]),
            .pre_i       (pre_s[b]),
            .apre_i      (cmd_apre),
            .cfg_wl      (cfg_wl),
            .cfg_bl      (cfg_bl),
            .cfg_twr     (cfg_twr),
            .cfg_tras    (cfg_tras),
            .cfg_trp     (cfg_trp),
            .state_o     (bank_state[2*b +: 2]),
            .pre_start_o (pre_start[b]),
            .act_err_o   (err_s[b])
        );
    end

    assign act_err = |err_s;

    AST_ERR_NEEDS_ACTIVATE: assert property (@(posedge clk) disable iff (!rst_n)
        act_err |-> $past(cmd_valid && cmd_op == OP_ACT)); // R7
endmodule

// File: tb/tb_apre_sched.sv
`timescale 1ns/1ps
module tb_apre_sched;
    localparam int NB = 4;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_op = 2'd0;
    logic [1:0]    cmd_bank = 2'd0;
    logic          cmd_apre = 1'b0;
    logic [CW-1:0] cfg_wl = 4'd2, cfg_bl = 4'd2, cfg_twr = 4'd5, cfg_tras = 4'd6, cfg_trp = 4'd3;
    logic [NB-1:0]   pre_start;
    logic [2*NB-1:0] bank_state;
    logic            act_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    apre_sched #(.NUM_BANKS(NB), .CFG_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_bank(cmd_bank), .cmd_apre(cmd_apre), .cfg_wl(cfg_wl), .cfg_bl(cfg_bl),
        .cfg_twr(cfg_twr), .cfg_tras(cfg_tras), .cfg_trp(cfg_trp),
        .pre_start(pre_start), .bank_state(bank_state), .act_err(act_err)
    );

    function automatic int st(input int b);
        return int'(bank_state[2*b +: 2]);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic issue(input int op, input int b, input bit ap);
        cmd_valid = 1'b1; cmd_op = 2'(op); cmd_bank = 2'(b); cmd_apre = ap;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 2'd0; cmd_bank = 2'd0; cmd_apre = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_pre(input int b, input int k, input string req);
        int early = 0;
        for (int i = 1; i <= k; i++) begin
            @(negedge clk);
            if (i < k && pre_start[b]) early = i;
        end
        chk(early == 0 && pre_start[b] && st(b) == 2, req, early * 100 + int'(pre_start[b]) * 10 + st(b), 12);
    endtask

    task automatic t_reset();
        chk(bank_state == '0, "R9 reset state", int'(bank_state), 0);
        chk(pre_start == '0 && !act_err, "R9 reset outputs", int'(pre_start), 0);
    endtask

    task automatic t_no_flag();
        int seen = 0;
        issue(0, 0, 0);
        chk(st(0) == 1, "R7 activate idle bank", st(0), 1);
        issue(1, 0, 0);
        issue(2, 0, 0);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (pre_start[0]) seen++;
        end
        chk(seen == 0 && st(0) == 1, "R1 no auto-precharge", seen * 10 + st(0), 1);
    endtask

    task automatic t_explicit_pre();
        issue(3, 0, 0);
        chk(pre_start[0] && st(0) == 2, "R5 explicit precharge", int'(pre_start[0]) * 10 + st(0), 12);
        @(negedge clk);
        chk(!pre_start[0] && st(0) == 2, "R11 one-cycle pulse", int'(pre_start[0]) * 10 + st(0), 2);
        @(negedge clk);
        chk(st(0) == 2, "R6 still precharging", st(0), 2);
        @(negedge clk);
        chk(st(0) == 0, "R6 back to idle", st(0), 0);
    endtask

    task automatic t_read_auto();
        issue(0, 1, 0);
        idle(10);
        issue(1, 1, 1);
        expect_pre(1, 2, "R2 read auto-precharge after burst");
        idle(5);
        chk(st(1) == 0, "R6 idle after read auto", st(1), 0);
    endtask

    task automatic t_lockout();
        issue(0, 2, 0);
        issue(1, 2, 1);
        expect_pre(2, 5, "R4 lockout delays read auto-precharge");
        idle(5);
    endtask

    task automatic t_write_auto();
        issue(0, 3, 0);
        idle(8);
        issue(2, 3, 1);
        expect_pre(3, 9, "R3 write wl+bl+twr");
        idle(5);
    endtask

    task automatic t_independent();
        issue(0, 0, 0);
        issue(0, 1, 0);
        idle(8);
        issue(1, 0, 1);
        expect_pre(0, 2, "R8 bank0 closes");
        chk(st(1) == 1 && !pre_start[1], "R8 bank1 untouched", st(1), 1);
        issue(3, 1, 0);
        chk(st(1) == 2, "R8 bank1 own precharge", st(1), 2);
        idle(5);
    endtask

    task automatic t_act_error();
        issue(0, 2, 0);
        chk(!act_err && st(2) == 1, "R7 clean activate", int'(act_err), 0);
        issue(0, 2, 0);
        chk(act_err && st(2) == 1, "R7 activate to active bank", int'(act_err) * 10 + st(2), 11);
        @(negedge clk);
        chk(!act_err, "R7 error pulse ends", int'(act_err), 0);
        issue(3, 2, 0);
        issue(0, 2, 0);
        chk(act_err && st(2) == 2, "R7 activate to precharging bank", int'(act_err) * 10 + st(2), 12);
        idle(5);
    endtask

    task automatic t_ignored();
        int seen = 0;
        issue(1, 3, 1);
        issue(2, 3, 1);
        for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            if (pre_start[3] || st(3) != 0) seen++;
        end
        chk(seen == 0, "R10 read/write to idle bank ignored", seen, 0);
        issue(3, 3, 0);
        chk(!pre_start[3] && st(3) == 0, "R5 precharge to idle ignored", int'(pre_start[3]) * 10 + st(3), 0);
    endtask

    task automatic t_write_cfg();
        cfg_wl = 4'd3; cfg_twr = 4'd1;
        issue(0, 3, 0);
        idle(8);
        issue(2, 3, 1);
        expect_pre(3, 6, "R3 write with wl=3 twr=1");
        idle(5);
        cfg_tras = 4'd12;
        issue(0, 0, 0);
        issue(2, 0, 1);
        expect_pre(0, 11, "R3 write held by lockout");
        idle(5);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_no_flag();
        t_explicit_pre();
        t_read_auto();
        t_lockout();
        t_write_auto();
        t_independent();
        t_act_error();
        t_ignored();
        t_write_cfg();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule